// File: doc/BRIEF.md
# System Sleep-State Sequencer

This block is a finite state machine that keeps track of the platform's global power state. It has six states. Three of them are on states: the CPU running, the CPU parked in an idle C-state, and a deep low-power idle that sits on top of the CPU idle state. The other three are suspend-to-disk, soft-off and mechanical-off. The block takes its triggers as inputs:

- a sleep-enable strobe with a requested sleep type;
- a power-button override;
- a power-fail indication and a power-return indication;
- level wake sources with an enable mask;
- CPU C-state entry and exit requests;
- south-side deep-idle entry and exit requests;
- an active-low battery-low flag.

It drives a one-hot state vector and two registered rail enables.

A small record survives a power loss. It holds the class of the last powered state, and together with a restore-policy input it decides where the system lands when power comes back. Wake requests that arrive from a sleep state while the battery is low are held pending. The held wake is taken on the first cycle in which the battery-low flag goes inactive.

Top module: `sleep_seq`

## Requirements
- R1: After reset the state is mechanical-off, both rail enables are 0, and the retained record reads soft-off. A first power return therefore lands in soft-off whatever the restore policy is.
- R2: `state_oh` is always one-hot, with these bit positions: 0 = run, 1 = CPU idle, 2 = deep idle, 3 = suspend-to-disk, 4 = soft-off, 5 = mechanical-off.
- R3: In run, `slp_en` moves to suspend-to-disk when `slp_type` is 0 and to soft-off when `slp_type` is 1. `slp_en` wins over `cpu_idle_req`. Otherwise `cpu_idle_req` moves to CPU idle.
- R4: In CPU idle, `cpu_wake_req` returns to run, and otherwise `deep_req` moves to deep idle. `deep_req` has no effect in any other state.
- R5: In deep idle, `cpu_wake_req` returns to run, and otherwise `deep_exit_req` returns to CPU idle.
- R6: `pwr_fail` moves any powered state to mechanical-off in the next cycle. It overrides every other trigger.
- R7: `btn_override` moves any powered state to soft-off. It is overridden only by `pwr_fail`, and it discards any pending wake.
- R8: In suspend-to-disk or soft-off, a wake source whose mask bit is set returns to run. A wake source whose mask bit is clear has no effect.
- R9: While `batlow_n` is 0, no wake leaves suspend-to-disk or soft-off. The wake stays pending, even after the source drops, and is taken on the first cycle with `batlow_n` at 1.
- R10: Mechanical-off is left only on `pwr_return`. The landing state depends on the retained record and on `restore_on`:
  - record soft-off: go to soft-off;
  - record run-class: go to run if `restore_on` is 1, otherwise to soft-off;
  - record suspend-to-disk: go to run if `restore_on` is 1, otherwise to suspend-to-disk.
- R11: `main_en` is 1 exactly in the three on states and `stby_en` is 1 in every state except mechanical-off. Both change in the same cycle as `state_oh`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slp_en | input | 1 | Sleep-enable strobe |
| slp_type | input | 1 | Requested sleep: 0 suspend-to-disk, 1 soft-off |
| btn_override | input | 1 | Power-button override |
| pwr_fail | input | 1 | Power-fail or mechanical-off indication |
| pwr_return | input | 1 | Power-return indication |
| restore_on | input | 1 | Restore policy after power loss |
| wake_src | input | NUM_WAKE | Level wake sources |
| wake_mask | input | NUM_WAKE | Per-source wake enable |
| cpu_idle_req | input | 1 | CPU C-state entry request |
| cpu_wake_req | input | 1 | CPU or south C-state exit request |
| deep_req | input | 1 | South request to enter deep idle |
| deep_exit_req | input | 1 | South request to leave deep idle |
| batlow_n | input | 1 | Battery-low, active low |
| state_oh | output | 6 | One-hot state vector |
| main_en | output | 1 | Main rail enable |
| stby_en | output | 1 | Standby rail enable |

## Verification
Some properties are checked by the assertions on every cycle:
- the state vector stays one-hot;
- power-fail and override take priority;
- mechanical-off stays put until power returns;
- deep idle is entered only from CPU idle;
- the sleep states are never left while the battery is low;
- the rail enables agree with the state.

Other behaviour depends on history, and only the bench scenarios can show it: a wake that stays pending after its source drops, and the landing state after power return, which depends on the record and the policy. A long pseudo-random run, compared against a reference model written from the requirements, covers the combinations of triggers within a cycle.

// File: rtl/sleep_seq.sv
module sleep_seq #(
  parameter int NUM_WAKE = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                slp_en,
  input  logic                slp_type,
  input  logic                btn_override,
  input  logic                pwr_fail,
  input  logic                pwr_return,
  input  logic                restore_on,
  input  logic [NUM_WAKE-1:0] wake_src,
  input  logic [NUM_WAKE-1:0] wake_mask,
  input  logic                cpu_idle_req,
  input  logic                cpu_wake_req,
  input  logic                deep_req,
  input  logic                deep_exit_req,
  input  logic                batlow_n,
  output logic [5:0]          state_oh,
  output logic                main_en,
  output logic                stby_en
);
  localparam logic [2:0] RUN = 3'd0, IDLE = 3'd1, DEEP = 3'd2,
                         DISK = 3'd3, SOFT = 3'd4, MOFF = 3'd5;
  localparam logic [1:0] REC_ON = 2'd0, REC_DISK = 2'd1, REC_SOFT = 2'd2;

  logic [2:0] st_q, st_d;
  logic [1:0] rec_q;
  logic       pend_q, pend_d;

  wire any_wake  = |(wake_src & wake_mask);
  wire sleeping  = (st_q == DISK) || (st_q == SOFT);
  wire want_wake = pend_q || any_wake;
  wire take_wake = want_wake && batlow_n;

  always_comb begin
    st_d = st_q;
    if (st_q == MOFF) begin
      if (pwr_return)
        case (rec_q)
          REC_SOFT: st_d = SOFT;
          REC_DISK: st_d = restore_on ? RUN : DISK;
          default:  st_d = restore_on ? RUN : SOFT;
        endcase
    end else if (pwr_fail)
      st_d = MOFF;
    else if (btn_override)
      st_d = SOFT;
    else
      case (st_q)
        RUN:  if (slp_en) st_d = slp_type ? SOFT : DISK;
              else if (cpu_idle_req) st_d = IDLE;
        IDLE: if (cpu_wake_req) st_d = RUN;
              else if (deep_req) st_d = DEEP;
        DEEP: if (cpu_wake_req) st_d = RUN;
              else if (deep_exit_req) st_d = IDLE;
        default: if (take_wake) st_d = RUN;
      endcase
  end

  assign pend_d = sleeping && want_wake && !pwr_fail && !btn_override && !batlow_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_q    <= MOFF;
      rec_q   <= REC_SOFT;
      pend_q  <= 1'b0;
      main_en <= 1'b0;
      stby_en <= 1'b0;
    end else begin
      st_q    <= st_d;
      pend_q  <= pend_d;
      main_en <= (st_d == RUN) || (st_d == IDLE) || (st_d == DEEP);
      stby_en <= (st_d != MOFF);
      if (st_q != MOFF)
        rec_q <= (st_q == DISK) ? REC_DISK : (st_q == SOFT) ? REC_SOFT : REC_ON;
    end

  assign state_oh = 6'b1 << st_q;
endmodule

module sleep_seq_chk #(
  parameter int NUM_WAKE = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_fail,
  input logic       btn_override,
  input logic       pwr_return,
  input logic       batlow_n,
  input logic [5:0] state_oh,
  input logic       main_en,
  input logic       stby_en
);
  wire powered = !state_oh[5];
  wire on_cls  = |state_oh[2:0];

  AST_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n) $countones(state_oh) == 1); // R2
  AST_DEEP_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n) $rose(state_oh[2]) |-> $past(state_oh[1])); // R4
  AST_FAIL_TO_MOFF: assert property (@(posedge clk) disable iff (!rst_n) powered && pwr_fail |=> state_oh[5]); // R6
  AST_OVERRIDE_SOFT: assert property (@(posedge clk) disable iff (!rst_n) powered && btn_override && !pwr_fail |=> state_oh[4]); // R7
  AST_BATLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (state_oh[3] || state_oh[4]) && !batlow_n |=> !on_cls); // R9
  AST_MOFF_STAYS: assert property (@(posedge clk) disable iff (!rst_n) state_oh[5] && !pwr_return |=> state_oh[5]); // R10
  AST_RAIL_MAIN: assert property (@(posedge clk) disable iff (!rst_n) main_en == on_cls); // R11
  AST_RAIL_STBY: assert property (@(posedge clk) disable iff (!rst_n) stby_en == powered); // R11
endmodule

bind sleep_seq sleep_seq_chk #(.NUM_WAKE(NUM_WAKE)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .btn_override(btn_override),
  .pwr_return(pwr_return), .batlow_n(batlow_n), .state_oh(state_oh),
  .main_en(main_en), .stby_en(stby_en)
);

// File: tb/tb_sleep_seq.sv
module tb_sleep_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 4;

  logic clk = 0, rst_n = 0;
  logic slp_en, slp_type, btn_override, pwr_fail, pwr_return, restore_on;
  logic [NW-1:0] wake_src, wake_mask;
  logic cpu_idle_req, cpu_wake_req, deep_req, deep_exit_req, batlow_n;
  logic [5:0] state_oh;
  logic main_en, stby_en;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_st, m_rec;
  bit m_pend;

  always #(CLK_PERIOD/2) clk = ~clk;

  sleep_seq #(.NUM_WAKE(NW)) dut (.*);

  task automatic idle_in();
    slp_en = 0; slp_type = 0; btn_override = 0; pwr_fail = 0; pwr_return = 0;
    restore_on = 0; wake_src = 0; wake_mask = '1; cpu_idle_req = 0;
    cpu_wake_req = 0; deep_req = 0; deep_exit_req = 0; batlow_n = 1;
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(string tag);
    int nx; bit np, wk, slp;
    wk  = |(wake_src & wake_mask);
    slp = (m_st == 3) || (m_st == 4);
    nx  = m_st;
    if (m_st == 5) begin
      if (pwr_return) nx = (m_rec == 2) ? 4 : restore_on ? 0 : (m_rec == 1) ? 3 : 4;
    end else if (pwr_fail) nx = 5;
    else if (btn_override) nx = 4;
    else if (m_st == 0) begin
      if (slp_en) nx = slp_type ? 4 : 3; else if (cpu_idle_req) nx = 1;
    end else if (m_st == 1) begin
      if (cpu_wake_req) nx = 0; else if (deep_req) nx = 2;
    end else if (m_st == 2) begin
      if (cpu_wake_req) nx = 0; else if (deep_exit_req) nx = 1;
    end else if ((m_pend || wk) && batlow_n) nx = 0;
    np = slp && (m_pend || wk) && !pwr_fail && !btn_override && !batlow_n;
    if (m_st != 5) m_rec = (m_st == 3) ? 1 : (m_st == 4) ? 2 : 0;
    @(posedge clk); #1;
    m_st = nx; m_pend = np;
    check(state_oh == (6'b1 << nx), tag, state_oh, 6'b1 << nx);
    check($countones(state_oh) == 1, "R2 one-hot", state_oh, 0);
    check(main_en == (nx <= 2) && stby_en == (nx != 5), "R11 rails",
          {main_en, stby_en}, {nx <= 2, nx != 5});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle_in();
    m_st = 5; m_rec = 2; m_pend = 0;
    #(CLK_PERIOD * 3); rst_n = 1; #1;
    check(state_oh == 6'b100000 && !main_en && !stby_en, "R1 reset", {state_oh, main_en, stby_en}, 8'b10000000);
    @(posedge clk); #1;
    pwr_fail = 0; btn_override = 1; slp_en = 1; cyc("R10 mech-off ignores other inputs");
    idle_in(); restore_on = 1; pwr_return = 1; cyc("R1 R10 first return lands soft-off");
    check(state_oh == 6'b010000, "R1 soft-off after first return", state_oh, 6'b010000);
    idle_in(); wake_src = 4'b0010; wake_mask = 4'b1101; cyc("R8 masked wake ignored");
    idle_in(); wake_src = 4'b0010; batlow_n = 0; cyc("R9 wake deferred");
    idle_in(); batlow_n = 0; cyc("R9 pending held with source gone");
    idle_in(); cyc("R9 pending taken on batlow release");
    check(state_oh == 6'b000001, "R9 in run", state_oh, 1);
    idle_in(); deep_req = 1; cyc("R4 deep request in run ignored");
    idle_in(); cpu_idle_req = 1; deep_req = 1; cyc("R4 enter cpu idle");
    idle_in(); deep_req = 1; cyc("R4 enter deep idle");
    idle_in(); deep_exit_req = 1; cyc("R5 south exit to cpu idle");
    idle_in(); deep_req = 1; cyc("R4 deep again");
    idle_in(); cpu_wake_req = 1; deep_exit_req = 1; cyc("R5 cpu exit to run");
    idle_in(); slp_en = 1; slp_type = 0; cpu_idle_req = 1; cyc("R3 sleep to disk");
    check(state_oh == 6'b001000, "R3 disk", state_oh, 6'b001000);
    idle_in(); btn_override = 1; wake_src = 1; cyc("R7 override wins over wake");
    idle_in(); wake_src = 4'b1000; cyc("R8 wake from soft-off");
    idle_in(); slp_en = 1; slp_type = 1; cyc("R3 sleep to soft-off");
    idle_in(); wake_src = 1; cyc("R8 wake");
    idle_in(); slp_en = 1; btn_override = 1; cyc("R7 override wins over sleep");
    idle_in(); wake_src = 1; cyc("R8 wake");
    idle_in(); pwr_fail = 1; btn_override = 1; cyc("R6 fail wins over override");
    idle_in(); restore_on = 1; pwr_return = 1; cyc("R10 run record restore on");
    idle_in(); slp_en = 1; cyc("R3 to disk");
    idle_in(); pwr_fail = 1; cyc("R6 fail from disk");
    idle_in(); pwr_return = 1; cyc("R10 disk record restore off");
    check(state_oh == 6'b001000, "R10 back in disk", state_oh, 6'b001000);
    idle_in(); pwr_fail = 1; cyc("R6 fail");
    idle_in(); pwr_return = 1; restore_on = 1; cyc("R10 disk record restore on");
    idle_in(); pwr_fail = 1; cyc("R6 fail from run");
    idle_in(); pwr_return = 1; cyc("R10 run record restore off");
    for (int i = 0; i < 30000; i++) begin
      logic [31:0] r;
      r = $urandom;
      slp_en = r[2:0] == 0; slp_type = r[3];
      btn_override = r[9:4] == 0; pwr_fail = r[15:10] == 0;
      pwr_return = r[17:16] == 0; restore_on = r[18];
      wake_src = (r[21:19] == 0) ? NW'($urandom) : '0; wake_mask = NW'($urandom);
      cpu_idle_req = r[22]; cpu_wake_req = r[24:23] == 0;
      deep_req = r[25]; deep_exit_req = r[27:26] == 0;
      batlow_n = ((i / 64) % 3) != 0 || r[28];
      cyc("R3 R4 R5 R6 R7 R8 R9 R10 sweep");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule